// File: doc/BRIEF.md
# Clock Tree Enable-Status Resolver

This block holds the control words of a small clock-generation tree and reports, for every node, whether that node is truly running. The tree has five integer dividers (A to E) and a row of base-clock selectors. Each node has a power-down bit and a five-bit source code. A node reports as running only when its own power-down bit is clear and the source it selects is running. Dividers B to E may take their input from divider A, so the answer is resolved through the whole chain down to the root sources.

Root sources (the 32 kHz oscillator, the internal RC oscillator, two Ethernet clocks, the general-purpose clock input, the crystal oscillator and three PLLs) are not modelled. Each one comes in as a single "running" input. A software agent writes and reads the control words through a simple word-addressed port. A clock consumer watches the per-node enable vector before it touches logic clocked by that node. The vector is purely combinational from the stored words and the root inputs.

Source codes: 0 osc32, 1 internal RC, 2 Ethernet receive, 3 Ethernet transmit, 4 general input, 5 reserved, 6 crystal, 7 USB PLL, 8 audio PLL, 9 main PLL, 10 and 11 reserved, 12 to 16 dividers A to E, and 17 to 31 unimplemented. Divider i sits at word address i (0 to 4). Base slot j sits at word address 16 + j (slots 0 to 27).

Top module: `clk_tree_status`

## Requirements
- R1: After reset, every divider and every gated base slot reads back with bit 0 (power-down) set, a source code of 1 and a divider field of 0. The USB0 base slot (slot 1) reads source code 7. nodeEn is zero except the safe-slot bit.
- R2: Bit 0 of a control word is power-down. Writing 1 makes that node's nodeEn bit 0 from the clock edge that takes the write. Writing 0 lets the node run if its source is running.
- R3: The source code sits in bits 28:24 and the divider value starts at bit 2. The divider value is 2 bits wide for A, 4 bits for B, C and D, and 8 bits for E. Bits above a divider's width read back as 0.
- R4: A node's nodeEn bit is 1 only when its power-down bit is clear and its selected source is running. This holds through cascades: when divider A stops, dividers selecting A and base slots selecting those dividers all read 0, even though their own gates are open.
- R5: nodeEn follows the rootRun inputs in the same cycle, with no register in between. rootRun bit k is source code k.
- R6: A write whose source code is not allowed for that node keeps the previous code, while the other fields are still written. Allowed codes are as follows. Divider A: 0-4, 6-9. Dividers B-E: 0-4, 6, 8, 9, 12. USB0 slot: 7 only. Slots 3, 20, 26 and 27: 0-4, 6-9, 12-16. All other gated slots: 0-4, 6, 8, 9, 12-16.
- R7: The safe slot (slot 0, address 16) always reads source code 1 with power-down 0 and ignores writes. Its nodeEn bit equals rootRun bit 1.
- R8: Base slots 21 to 24 read as 0, ignore writes, and their nodeEn bits stay 0.
- R9: rdData and rdValid appear on the clock edge after the one that samples rdEn. Addresses that map to no node read as 0.

Bit order of nodeEn: bits 0 to 4 are dividers A to E, and bit 5 + j is base slot j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the word at addr |
| rdEn | input | 1 | Read strobe for the word at addr |
| addr | input | ADDR_W (6) | Word address |
| wrData | input | DATA_W (32) | Write data |
| rootRun | input | 10 | Running flag for each root source code 0 to 9 |
| rdData | output | DATA_W (32) | Read-back word |
| rdValid | output | 1 | rdData holds the result of the previous read |
| nodeEn | output | 5 + NUM_BASE (33) | Effective enable of every node |

## Verification
A write takes effect on the rising edge that samples wrEn. The bench therefore checks nodeEn at the falling edge that follows that rising edge. Changes on rootRun reach nodeEn with no clock at all, so those checks sample one time unit after rootRun is driven, well away from any edge. A read result is due one rising edge after rdEn. The driver pushes the expected word into a queue when it raises rdEn. A monitor pops and compares at the next falling edge on which rdValid is high, and it flags any result that has no expected item or any item that was never consumed.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;

  localparam int NUM_DIV   = 5;
  localparam int NUM_ROOT  = 10;
  localparam int SEL_W     = 5;
  localparam int SEL_LSB   = 24;
  localparam int DIV_LSB   = 2;
  localparam int DIV_MAX_W = 8;
  localparam int IDX_W     = 5;
  localparam int CODES     = 1 << SEL_W;

  localparam logic [SEL_W-1:0] SRC_IRC     = 5'd1;
  localparam logic [SEL_W-1:0] SRC_RSVD    = 5'd5;
  localparam logic [SEL_W-1:0] SRC_PLL_USB = 5'd7;
  localparam int               SRC_DIV0    = 12;

  typedef enum logic [2:0] {
    K_DIV_A, K_DIV_BE, K_SAFE, K_USB0, K_COMMON, K_ALL, K_RSVD
  } nodeKind_e;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic             isDiv;
    logic             isBase;
    logic [IDX_W-1:0] idx;
  } regStb_t;

  function automatic logic [CODES-1:0] allowedMask(nodeKind_e k);
    logic [CODES-1:0] roots;
    roots = 32'h0000_005F;
    case (k)
      K_DIV_A:  return roots | 32'h0000_0380;
      K_DIV_BE: return roots | 32'h0000_1300;
      K_SAFE:   return 32'h0000_0002;
      K_USB0:   return 32'h0000_0080;
      K_COMMON: return roots | 32'h0001_F300;
      K_ALL:    return roots | 32'h0001_F380;
      default:  return '0;
    endcase
  endfunction

  function automatic int divWidth(int i);
    if (i == 0) return 2;
    if (i == NUM_DIV - 1) return 8;
    return 4;
  endfunction

  function automatic nodeKind_e baseKind(int s);
    if (s == 0) return K_SAFE;
    if (s == 1) return K_USB0;
    if (s >= 21 && s <= 24) return K_RSVD;
    if (s == 3 || s == 20 || s == 26 || s == 27) return K_ALL;
    return K_COMMON;
  endfunction

endpackage

// File: rtl/clk_tree_ctrl.sv
module clk_tree_ctrl
  import clk_tree_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 16,
  parameter int NUM_BASE  = 28
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output regStb_t           stb
);

  logic [ADDR_W-1:0] baseOff;
  logic              hitDiv;
  logic              hitBase;

  always_comb begin
    baseOff = addr - ADDR_W'(BASE_ADDR);
    hitDiv  = (int'(addr) < NUM_DIV);
    hitBase = (int'(addr) >= BASE_ADDR) && (int'(addr) < BASE_ADDR + NUM_BASE);
    stb.wr     = wrEn;
    stb.rd     = rdEn;
    stb.isDiv  = hitDiv;
    stb.isBase = hitBase;
    stb.idx    = hitBase ? baseOff[IDX_W-1:0] : addr[IDX_W-1:0];
  end

endmodule

// File: rtl/clk_tree_regs.sv
module clk_tree_regs
  import clk_tree_pkg::*;
#(
  parameter int NUM_BASE = 28,
  parameter int DATA_W   = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStb_t                        stb,
  input  logic [DATA_W-1:0]              wrData,
  output logic [NUM_DIV-1:0]             divPd,
  output logic [NUM_DIV-1:0][SEL_W-1:0]  divSel,
  output logic [NUM_BASE-1:0]            basePd,
  output logic [NUM_BASE-1:0][SEL_W-1:0] baseSel,
  output logic [DATA_W-1:0]              rdData,
  output logic                           rdValid
);

  logic [DATA_W-1:0] divWord  [NUM_DIV];
  logic [DATA_W-1:0] baseWord [NUM_BASE];
  logic [SEL_W-1:0]  newSel;
  logic [DATA_W-1:0] rdMux;

  assign newSel = wrData[SEL_LSB +: SEL_W];

  for (genvar i = 0; i < NUM_DIV; i++) begin : gDiv
    localparam int               W    = divWidth(i);
    localparam logic [CODES-1:0] MASK = allowedMask((i == 0) ? K_DIV_A : K_DIV_BE);
    logic             pdQ;
    logic [SEL_W-1:0] selQ;
    logic [W-1:0]     divQ;
    logic             hit;

    assign hit = stb.wr && stb.isDiv && (stb.idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pdQ  <= 1'b1;
        selQ <= SRC_IRC;
        divQ <= '0;
      end else if (hit) begin
        pdQ  <= wrData[0];
        divQ <= wrData[DIV_LSB +: W];
        if (MASK[newSel]) selQ <= newSel;
      end
    end

    always_comb begin
      divWord[i]                    = '0;
      divWord[i][0]                 = pdQ;
      divWord[i][DIV_LSB +: W]      = divQ;
      divWord[i][SEL_LSB +: SEL_W]  = selQ;
    end

    assign divPd[i]  = pdQ;
    assign divSel[i] = selQ;
  end

  for (genvar j = 0; j < NUM_BASE; j++) begin : gBase
    localparam nodeKind_e        KIND = baseKind(j);
    localparam logic [CODES-1:0] MASK = allowedMask(KIND);
    logic             pdQ;
    logic [SEL_W-1:0] selQ;

    if (KIND == K_RSVD) begin : gRsvd
      assign pdQ  = 1'b1;
      assign selQ = '0;
      assign baseWord[j] = '0;
    end else if (KIND == K_SAFE) begin : gSafe
      assign pdQ  = 1'b0;
      assign selQ = SRC_IRC;
      always_comb begin
        baseWord[j]                   = '0;
        baseWord[j][SEL_LSB +: SEL_W] = selQ;
      end
    end else begin : gGated
      localparam logic [SEL_W-1:0] RST_SEL = (KIND == K_USB0) ? SRC_PLL_USB : SRC_IRC;
      logic hit;
      assign hit = stb.wr && stb.isBase && (stb.idx == IDX_W'(j));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          pdQ  <= 1'b1;
          selQ <= RST_SEL;
        end else if (hit) begin
          pdQ <= wrData[0];
          if (MASK[newSel]) selQ <= newSel;
        end
      end

      always_comb begin
        baseWord[j]                   = '0;
        baseWord[j][0]                = pdQ;
        baseWord[j][SEL_LSB +: SEL_W] = selQ;
      end
    end

    assign basePd[j]  = pdQ;
    assign baseSel[j] = selQ;
  end

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_DIV; i++)
      if (stb.isDiv && stb.idx == IDX_W'(i)) rdMux = divWord[i];
    for (int j = 0; j < NUM_BASE; j++)
      if (stb.isBase && stb.idx == IDX_W'(j)) rdMux = baseWord[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rd;
      if (stb.rd) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/clk_tree_resolve.sv
module clk_tree_resolve
  import clk_tree_pkg::*;
#(
  parameter int NUM_BASE = 28
) (
  input  logic [NUM_ROOT-1:0]            rootRun,
  input  logic [NUM_DIV-1:0]             divPd,
  input  logic [NUM_DIV-1:0][SEL_W-1:0]  divSel,
  input  logic [NUM_BASE-1:0]            basePd,
  input  logic [NUM_BASE-1:0][SEL_W-1:0] baseSel,
  output logic [NUM_DIV+NUM_BASE-1:0]    nodeEn
);

  // Three stages break the cascade without a combinational loop:
  // roots feed divider A, roots plus A feed B-E, everything feeds bases.
  logic [CODES-1:0]   rootVec;
  logic [CODES-1:0]   firstVec;
  logic [CODES-1:0]   fullVec;
  logic [NUM_DIV-1:0] divEn;

  always_comb begin
    rootVec = '0;
    rootVec[NUM_ROOT-1:0] = rootRun;
    rootVec[SRC_RSVD] = 1'b0;
  end

  assign divEn[0] = !divPd[0] && rootVec[divSel[0]];

  always_comb begin
    firstVec = rootVec;
    firstVec[SRC_DIV0] = divEn[0];
  end

  for (genvar i = 1; i < NUM_DIV; i++) begin : gDivEn
    assign divEn[i] = !divPd[i] && firstVec[divSel[i]];
  end

  always_comb begin
    fullVec = rootVec;
    fullVec[SRC_DIV0 +: NUM_DIV] = divEn;
  end

  assign nodeEn[NUM_DIV-1:0] = divEn;

  for (genvar j = 0; j < NUM_BASE; j++) begin : gBaseEn
    assign nodeEn[NUM_DIV + j] = !basePd[j] && fullVec[baseSel[j]];
  end

endmodule

// File: rtl/clk_tree_status.sv
module clk_tree_status
  import clk_tree_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 16,
  parameter int NUM_BASE  = 28,
  parameter int DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [NUM_ROOT-1:0]         rootRun,
  output logic [DATA_W-1:0]           rdData,
  output logic                        rdValid,
  output logic [NUM_DIV+NUM_BASE-1:0] nodeEn
);

  regStb_t                        stb;
  logic [NUM_DIV-1:0]             divPd;
  logic [NUM_DIV-1:0][SEL_W-1:0]  divSel;
  logic [NUM_BASE-1:0]            basePd;
  logic [NUM_BASE-1:0][SEL_W-1:0] baseSel;

  clk_tree_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_BASE(NUM_BASE)
  ) uCtrl (
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .stb(stb)
  );

  clk_tree_regs #(
    .NUM_BASE(NUM_BASE), .DATA_W(DATA_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .divPd(divPd), .divSel(divSel), .basePd(basePd), .baseSel(baseSel),
    .rdData(rdData), .rdValid(rdValid)
  );

  clk_tree_resolve #(
    .NUM_BASE(NUM_BASE)
  ) uResolve (
    .rootRun(rootRun), .divPd(divPd), .divSel(divSel),
    .basePd(basePd), .baseSel(baseSel), .nodeEn(nodeEn)
  );

endmodule

// File: rtl/clk_tree_status_chk.sv
module clk_tree_status_chk
  import clk_tree_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int BASE_ADDR = 16,
  parameter int NUM_BASE  = 28,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        wrEn,
  input logic                        rdEn,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wrData,
  input logic [NUM_ROOT-1:0]         rootRun,
  input logic [DATA_W-1:0]           rdData,
  input logic                        rdValid,
  input logic [NUM_DIV+NUM_BASE-1:0] nodeEn
);

  logic mapped;
  assign mapped = (int'(addr) < NUM_DIV) ||
                  ((int'(addr) >= BASE_ADDR) && (int'(addr) < BASE_ADDR + NUM_BASE));

  p_pd_stops_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(addr) < NUM_DIV && wrData[0]) |=> !nodeEn[$past(addr)]);

  p_safe_irc_r7: assert property (@(posedge clk) disable iff (!rstN)
    nodeEn[NUM_DIV] == rootRun[SRC_IRC]);

  p_usb0_src_r6: assert property (@(posedge clk) disable iff (!rstN)
    nodeEn[NUM_DIV + 1] |-> rootRun[SRC_PLL_USB]);

  p_rd_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  p_rd_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  p_rd_unmapped_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (rdData == '0));

  if (NUM_BASE > 24) begin : gRsvdChk
    p_rsvd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
      nodeEn[NUM_DIV + 21 +: 4] == 4'b0000);
  end

endmodule

bind clk_tree_status clk_tree_status_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_BASE(NUM_BASE), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
  .wrData(wrData), .rootRun(rootRun), .rdData(rdData), .rdValid(rdValid),
  .nodeEn(nodeEn)
);

// File: tb/clk_tree_status_test.sv
`timescale 1ns/1ps
module clk_tree_status_test;
  localparam int NODES = 33;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [9:0]  rootRun = '1;
  logic [31:0] rdData;
  logic        rdValid;
  logic [NODES-1:0] nodeEn;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  clk_tree_status uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rootRun(rootRun), .rdData(rdData), .rdValid(rdValid),
    .nodeEn(nodeEn)
  );

  task automatic note(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic chkEn(input int idx, input logic exp, input string tag);
    note(nodeEn[idx] === exp, tag, 64'(nodeEn[idx]), 64'(exp));
  endtask

  // Monitor: pop one expected item for every read result.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        note(1'b0, "R9 unexpected rdValid", 64'(rdData), 64'(0));
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        note(rdData === e, t, 64'(rdData), 64'(e));
      end
    end
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    note(nodeEn === 33'h20, "R1 nodeEn after reset", 64'(nodeEn), 64'h20);
    rd(6'd0,  32'h0100_0001, "R1 divider A reset word");
    rd(6'd17, 32'h0700_0001, "R1 usb0 reset word");
    rd(6'd18, 32'h0100_0001, "R1 common slot reset word");
    rd(6'd16, 32'h0100_0000, "R7 safe reset word");

    // R3 field positions and widths, R2 gate opening
    wr(6'd0, 32'h0600_003C);
    chkEn(0, 1'b1, "R2 divider A runs");
    rd(6'd0, 32'h0600_000C, "R3 divider A 2-bit field");
    wr(6'd4, 32'h0C00_03FC);
    rd(6'd4, 32'h0C00_03FC, "R3 divider E 8-bit field");
    chkEn(4, 1'b1, "R4 divider E from A");
    wr(6'd1, 32'h0C00_03FC);
    rd(6'd1, 32'h0C00_003C, "R3 divider B 4-bit field");
    wr(6'd2, 32'h0100_0FFC);
    rd(6'd2, 32'h0100_003C, "R3 divider C 4-bit field");
    chkEn(2, 1'b1, "R2 divider C runs");
    wr(6'd2, 32'h0100_0001);
    chkEn(2, 1'b0, "R2 divider C powered down");

    // R4 cascade
    wr(6'd18, 32'h0D00_0000);
    chkEn(7, 1'b1, "R4 slot 2 from divider B");
    wr(6'd0, 32'h0600_000D);
    chkEn(0, 1'b0, "R2 divider A stopped");
    chkEn(1, 1'b0, "R4 divider B cascades off");
    chkEn(4, 1'b0, "R4 divider E cascades off");
    chkEn(7, 1'b0, "R4 slot 2 cascades off");
    rd(6'd1, 32'h0C00_003C, "R4 divider B gate still open");
    wr(6'd0, 32'h0600_000C);
    chkEn(7, 1'b1, "R4 slot 2 back on");

    // R5 root inputs, combinational
    @(negedge clk);
    rootRun[6] = 1'b0;
    #1;
    chkEn(0, 1'b0, "R5 A off with crystal");
    chkEn(7, 1'b0, "R5 slot 2 off with crystal");
    chkEn(5, 1'b1, "R5 safe unaffected");
    rootRun[6] = 1'b1;
    #1;
    chkEn(7, 1'b1, "R5 slot 2 on again");
    wr(6'd19, 32'h0700_0000);
    chkEn(8, 1'b1, "R5 slot 3 on USB PLL");
    @(negedge clk);
    rootRun[7] = 1'b0;
    #1;
    chkEn(8, 1'b0, "R5 slot 3 follows USB PLL");
    rootRun[7] = 1'b1;

    // R6 disallowed codes
    wr(6'd0, 32'h0C00_0000);
    rd(6'd0, 32'h0600_0000, "R6 divider A refuses divider code");
    chkEn(0, 1'b1, "R6 divider A still on crystal");
    wr(6'd18, 32'h0700_0000);
    rd(6'd18, 32'h0D00_0000, "R6 common slot refuses USB PLL");
    wr(6'd17, 32'h0100_0000);
    rd(6'd17, 32'h0700_0000, "R6 usb0 keeps USB PLL");
    chkEn(6, 1'b1, "R6 usb0 runs");
    wr(6'd1, 32'h0700_0000);
    rd(6'd1, 32'h0C00_0000, "R6 divider B refuses USB PLL");
    wr(6'd1, 32'h0500_0000);
    rd(6'd1, 32'h0C00_0000, "R6 divider B refuses reserved code");

    // R7 safe slot
    wr(6'd16, 32'h0900_0001);
    rd(6'd16, 32'h0100_0000, "R7 safe ignores write");
    chkEn(5, 1'b1, "R7 safe still on");
    @(negedge clk);
    rootRun[1] = 1'b0;
    #1;
    chkEn(5, 1'b0, "R7 safe follows RC oscillator");
    rootRun[1] = 1'b1;

    // R8 reserved slots
    for (int s = 21; s <= 24; s++) begin
      wr(6'(16 + s), 32'h0100_0000);
      rd(6'(16 + s), 32'h0, "R8 reserved slot reads zero");
      chkEn(5 + s, 1'b0, "R8 reserved slot disabled");
    end

    // R9 unmapped addresses and last slot
    rd(6'd5,  32'h0, "R9 unmapped 5");
    rd(6'd10, 32'h0, "R9 unmapped 10");
    rd(6'd44, 32'h0, "R9 unmapped 44");
    rd(6'd63, 32'h0, "R9 unmapped 63");
    wr(6'd43, 32'h0900_0000);
    rd(6'd43, 32'h0900_0000, "R3 slot 27 word");
    chkEn(32, 1'b1, "R4 slot 27 on main PLL");

    repeat (4) @(negedge clk);
    note(expQ.size() == 0, "R9 pending reads", 64'(expQ.size()), 64'(0));
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule